// File: doc/BRIEF.md
# Sixty-four line interrupt controller with IRQ and FIQ outputs

The block collects 64 interrupt request lines and turns them into two processor interrupt outputs, a normal one (IRQ) and a fast one (FIQ). Each line has a one-byte control register. That byte enables the line, selects how the line is detected (high level, rising edge, falling edge, or both edges) and picks one of eight destinations. Only destinations 0 (IRQ) and 1 (FIQ) drive an output. Lines sent to destinations 2 to 7 are recorded in the status words and drive neither output.

Every input first passes through a two-flop synchronizer. Edge events are held in two 32-bit status words until software clears them by writing ones. Level-mode status bits show the synchronized line directly. Software reads a pending-number register for each output, and that register gives the number of the winning pending source. Each output has its own priority control bit that switches arbitration from fixed order to round-robin. The register bus is a simple single-cycle interface with a word address and byte enables. Write data is taken at the clock edge. Read data is combinational from the address.

Top module: `intc64`

## Requirements
- R1: After reset every control byte is 0x00, so every line is disabled, level-mode and routed to IRQ. Both priority control registers read 0. `irq_o` and `fiq_o` are low, and both pending-number registers read 63.
- R2: With control bit 5 set, a 0-to-1 transition of a synchronized line sets its status bit. This happens whether or not the line is enabled. The bit stays set until software clears it.
- R3: With control bit 6 set, a 1-to-0 transition sets the status bit. With bits 5 and 6 both set, either transition sets it. A transition of the wrong polarity leaves the bit at 0.
- R4: The status words sit at byte offset 0x80 (word address 0x20, sources 0 to 31 in bits 0 to 31) and at 0x84 (word address 0x21, sources 32 to 63). Writing 1 to an edge-mode bit clears it. Writing 0 leaves it unchanged. A new event in the same cycle as the clear keeps the bit set.
- R5: When control bits 5 and 6 are both 0, the status bit equals the synchronized line, and writes to the status words have no effect on it.
- R6: Control bit 3 enables the line, and bits 2:0 give its destination. `irq_o` is the OR of enabled status bits with destination 0. `fiq_o` is the OR of enabled status bits with destination 1. Destinations 2 to 7 and disabled lines drive neither output.
- R7: Offset 0x00 (word address 0) returns the IRQ winner in bits 5:0, and offset 0x04 (word address 1) returns the FIQ winner. When nothing is pending, each returns 63. A real pending source 63 also returns 63, and bit 31 of the word at 0x84 tells the two cases apart.
- R8: In fixed mode the pending source with the lowest number wins.
- R9: Bit 6 of the register at 0x20 (word 8) turns on rotation for IRQ, and bit 6 of the register at 0x24 (word 9) does the same for FIQ. A read of a pending-number register while a source is pending records that number. In rotating mode the search then starts at the next higher number and wraps after 63.
- R10: Control bytes for source n occupy byte offset 0x40+n. A word at 0x40+4k holds sources 4k to 4k+3, with the lowest source in bits 7:0. Only bytes whose byte enable is set are written, and the word reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 64 | Interrupt request lines, asynchronous |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_waddr | input | 6 | Word address (byte offset / 4) |
| bus_be | input | 4 | Byte enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench separates an idle controller from a real pending source 63. A design that stopped returning 63 when idle, or that failed to set status bit 31 for the real source, would leave software unable to tell the two apart. It checks that a write of zeros and a write to a level-mode bit leave status intact. A design with a plain write-through status register would lose events or fake a clear. It also checks that opposite-polarity edges and auxiliary destinations do not raise an output, and it confirms the exact rotation order 7, 50, 2, 7 across the wrap point. Any off-by-one in the rotation start would reorder that sequence.

// File: rtl/intc64.sv
module intc64 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] irq_src,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [5:0]  bus_waddr,
  input  logic [3:0]  bus_be,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_o,
  output logic        fiq_o
);

  logic [7:0]  ctl [64];
  logic [63:0] s1, s2, prev, stat_q, stat, ev, clr;
  logic [63:0] edge_m, rise_m, fall_m, pend_irq, pend_fiq;
  logic        rot_irq, rot_fiq;
  logic [5:0]  last_irq, last_fiq, irq_num, fiq_num;
  logic [31:0] bemask;

  wire we = bus_sel & bus_wr;
  wire re = bus_sel & ~bus_wr;
  assign bemask = {{8{bus_be[3]}}, {8{bus_be[2]}}, {8{bus_be[1]}}, {8{bus_be[0]}}};

  function automatic logic [5:0] pick(input logic [63:0] v, input logic [5:0] start);
    logic [5:0] r, idx;
    logic hit;
    r = 6'd63;
    hit = 1'b0;
    for (int k = 0; k < 64; k++) begin
      idx = start + 6'(k);
      if (!hit && v[idx]) begin
        r = idx;
        hit = 1'b1;
      end
    end
    return r;
  endfunction

  always_comb
    for (int i = 0; i < 64; i++) begin
      rise_m[i]   = ctl[i][5];
      fall_m[i]   = ctl[i][6];
      edge_m[i]   = ctl[i][5] | ctl[i][6];
      pend_irq[i] = stat[i] & ctl[i][3] & (ctl[i][2:0] == 3'd0);
      pend_fiq[i] = stat[i] & ctl[i][3] & (ctl[i][2:0] == 3'd1);
    end

  assign ev   = (s2 & ~prev & rise_m) | (~s2 & prev & fall_m);
  assign clr  = {(we && bus_waddr == 6'h21) ? bus_wdata & bemask : 32'd0,
                 (we && bus_waddr == 6'h20) ? bus_wdata & bemask : 32'd0};
  assign stat = (edge_m & stat_q) | (~edge_m & s2);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; prev <= '0; stat_q <= '0;
    end else begin
      s1 <= irq_src;
      s2 <= s1;
      prev <= s2;
      stat_q <= edge_m & ((stat_q & ~clr) | ev);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) ctl[i] <= 8'h00;
    end else if (we && bus_waddr[5:4] == 2'b01) begin
      for (int i = 0; i < 64; i++)
        if (bus_waddr[3:0] == 4'(i / 4) && bus_be[i % 4])
          ctl[i] <= bus_wdata[8*(i%4) +: 8];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rot_irq <= 1'b0; rot_fiq <= 1'b0;
      last_irq <= 6'd63; last_fiq <= 6'd63;
    end else begin
      if (we && bus_waddr == 6'd8 && bus_be[0]) rot_irq <= bus_wdata[6];
      if (we && bus_waddr == 6'd9 && bus_be[0]) rot_fiq <= bus_wdata[6];
      if (re && bus_waddr == 6'd0 && irq_o) last_irq <= irq_num;
      if (re && bus_waddr == 6'd1 && fiq_o) last_fiq <= fiq_num;
    end

  assign irq_num = pick(pend_irq, rot_irq ? last_irq + 6'd1 : 6'd0);
  assign fiq_num = pick(pend_fiq, rot_fiq ? last_fiq + 6'd1 : 6'd0);
  assign irq_o = |pend_irq;
  assign fiq_o = |pend_fiq;

  always_comb begin
    bus_rdata = 32'd0;
    case (bus_waddr)
      6'd0:  bus_rdata = {26'd0, irq_num};
      6'd1:  bus_rdata = {26'd0, fiq_num};
      6'd8:  bus_rdata = {25'd0, rot_irq, 6'd0};
      6'd9:  bus_rdata = {25'd0, rot_fiq, 6'd0};
      6'h20: bus_rdata = stat[31:0];
      6'h21: bus_rdata = stat[63:32];
      default:
        if (bus_waddr[5:4] == 2'b01)
          bus_rdata = {ctl[{bus_waddr[3:0], 2'd3}], ctl[{bus_waddr[3:0], 2'd2}],
                       ctl[{bus_waddr[3:0], 2'd1}], ctl[{bus_waddr[3:0], 2'd0}]};
    endcase
  end

  p_edge_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr == 64'd0) |=> ((($past(stat) & ~stat) & $past(edge_m) & edge_m) == 64'd0));

  p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr != 64'd0) |=> ((stat & edge_m & $past(clr & edge_m & ~ev)) == 64'd0));

  p_idle_num_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (irq_num == 6'd63));

  p_irq_winner_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> pend_irq[irq_num]);

  p_fiq_winner_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> pend_fiq[fiq_num]);

endmodule

// File: tb/sim_intc64.sv
module sim_intc64;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [63:0] irq_src = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_waddr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, rd;
  logic        irq_o, fiq_o;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  intc64 u0 (.clk, .rst_n, .irq_src, .bus_sel, .bus_wr, .bus_waddr, .bus_be,
             .bus_wdata, .bus_rdata, .irq_o, .fiq_o);

  // {src[31:24], ctl[23:16], init[9], final[8], stat[2], irq[1], fiq[0]}
  localparam logic [31:0] VEC [8] = '{
    32'h05280106,  // R2 rising, IRQ
    32'h28490205,  // R3 falling, FIQ
    32'h0A200104,  // R2 R6 disabled line still latches
    32'h0C280200,  // R3 wrong polarity
    32'h21080106,  // R5 level high, IRQ
    32'h3F6A0204,  // R3 R6 both edges, aux destination
    32'h14090105,  // R5 R6 level high, FIQ
    32'h01480100   // R3 falling mode ignores rise
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_waddr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rdw(logic [5:0] a);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_waddr = a;
    #1 rd = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_ctl(int s, logic [7:0] c);
    wr(6'(16 + s / 4), 4'(1 << (s % 4)), 32'(c) << (8 * (s % 4)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq_o", 32'(irq_o), 0);
    check("R1 fiq_o", 32'(fiq_o), 0);
    rdw(6'd0);  check("R1 irq num", rd, 63);
    rdw(6'd1);  check("R1 fiq num", rd, 63);
    rdw(6'd16); check("R1 ctl word", rd, 0);
    rdw(6'd31); check("R1 ctl word top", rd, 0);
    rdw(6'd8);  check("R1 prio", rd, 0);

    foreach (VEC[i]) begin
      automatic int s = int'(VEC[i][31:24]);
      automatic logic [5:0] sw = (s < 32) ? 6'h20 : 6'h21;
      irq_src[s] = VEC[i][9];
      settle();
      set_ctl(s, VEC[i][23:16]);
      wr(sw, 4'hF, 32'hFFFF_FFFF);
      irq_src[s] = VEC[i][8];
      settle();
      rdw(sw);
      check($sformatf("R2 R3 R5 status src%0d", s), 32'(rd[s % 32]), 32'(VEC[i][2]));
      check($sformatf("R6 irq src%0d", s), 32'(irq_o), 32'(VEC[i][1]));
      check($sformatf("R6 fiq src%0d", s), 32'(fiq_o), 32'(VEC[i][0]));
      if (VEC[i][1]) begin rdw(6'd0); check("R7 irq num", rd, 32'(s)); end
      if (VEC[i][0]) begin rdw(6'd1); check("R7 fiq num", rd, 32'(s)); end
      set_ctl(s, 8'h00);
      irq_src = '0;
      settle();
      wr(6'h20, 4'hF, 32'hFFFF_FFFF);
      wr(6'h21, 4'hF, 32'hFFFF_FFFF);
    end

    // R4 write-one-to-clear
    set_ctl(3, 8'h28);
    irq_src[3] = 1'b1;
    settle();
    wr(6'h20, 4'hF, 32'h0000_0000);
    rdw(6'h20); check("R4 zero write keeps", 32'(rd[3]), 1);
    wr(6'h20, 4'hF, 32'h0000_0008);
    rdw(6'h20); check("R4 one clears", 32'(rd[3]), 0);
    check("R4 irq after clear", 32'(irq_o), 0);
    set_ctl(3, 8'h00);
    irq_src = '0;
    settle();

    // R7 idle 63 versus real source 63
    rdw(6'd0);  check("R7 idle num", rd, 63);
    rdw(6'h21); check("R7 idle bit31", 32'(rd[31]), 0);
    set_ctl(63, 8'h08);
    irq_src[63] = 1'b1;
    settle();
    rdw(6'd0);  check("R7 real num", rd, 63);
    rdw(6'h21); check("R7 real bit31", 32'(rd[31]), 1);
    check("R7 irq_o", 32'(irq_o), 1);
    set_ctl(63, 8'h00);
    irq_src = '0;
    settle();

    // R10 word and byte access
    wr(6'd17, 4'hF, 32'h0A09_0828);
    rdw(6'd17); check("R10 word", rd, 32'h0A09_0828);
    wr(6'd17, 4'b0100, 32'h5533_7711);
    rdw(6'd17); check("R10 byte", rd, 32'h0A33_0828);
    wr(6'd17, 4'hF, 32'h0);

    // R8 fixed priority, R5 write ignored on level bit
    set_ctl(2, 8'h08); set_ctl(7, 8'h08); set_ctl(50, 8'h08);
    irq_src[2] = 1'b1; irq_src[7] = 1'b1; irq_src[50] = 1'b1;
    settle();
    rdw(6'd0); check("R8 fixed first", rd, 2);
    rdw(6'd0); check("R8 fixed again", rd, 2);
    wr(6'h20, 4'hF, 32'h0000_0004);
    rdw(6'h20); check("R5 level ignores write", 32'(rd[2]), 1);

    // R9 rotation (last reported = 2)
    wr(6'd8, 4'b0001, 32'h40);
    rdw(6'd8); check("R9 prio readback", rd, 32'h40);
    rdw(6'd0); check("R9 rot 1", rd, 7);
    rdw(6'd0); check("R9 rot 2", rd, 50);
    rdw(6'd0); check("R9 rot wrap", rd, 2);
    rdw(6'd0); check("R9 rot 4", rd, 7);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule